// File: doc/BRIEF.md
# Multiplexed Voltage-ID Pin Driver

This block presents a 6-bit core-voltage identification code to an external regulator over only four output pins. Pin 3 selects the phase. Pins 2:0 carry one half of the code at a time. When pin 3 is low they carry code bits 2:0, and when pin 3 is high they carry code bits 5:3. A sequence always shows the low half first and the high half second. Each half is held for a minimum time so the regulator can latch it.

All timing is counted in system-clock cycles. The minimum hold is given in nanoseconds and converted to cycles at elaboration from the clock-frequency parameter. The maximum phase length is given directly in cycles. After reset the block runs one sequence with a default code. Later sequences start when a request arrives while the block is idle. The code is captured at that moment. When the high half has been held long enough, the block raises a one-cycle completion pulse. A parameter then decides what happens next: either the pins stay on the high half, or they fall back to the low half once the high phase reaches its maximum length.

Top module: `vid_pin_mux`

## Requirements
- R1: While reset is asserted, pin 3 is 0, pins 2:0 equal bits 2:0 of the reset-default code, busy is 1 and done is 0.
- R2: After reset is released, the block runs a full sequence with the reset-default code. Pin 3 rises after the low phase, and pins 2:0 then show bits 5:3 of that code.
- R3: On every cycle, pins 2:0 equal bits 2:0 of the captured code when pin 3 is 0, and bits 5:3 when pin 3 is 1.
- R4: Within a sequence, the low phase comes first and the high phase second. Each phase lasts exactly the minimum-hold cycle count, which is the hold time in ns times the clock frequency, rounded up to whole cycles. No phase-select edge ever follows a phase shorter than that count.
- R5: Pins 2:0 switch to the new half in the same cycle that pin 3 changes.
- R6: done is high for exactly one cycle, namely the first cycle after the high phase meets its minimum hold. busy falls in that same cycle.
- R7: A request is accepted only in a cycle where busy is 0. A request while busy is ignored and starts no later sequence.
- R8: The code is captured in the cycle the request is accepted. Changes to the code input after that cycle do not alter the sequence in progress.
- R9: With the park parameter at 0, the pins stay on the high half after done until the next request.
- R10: With the park parameter at 1, pin 3 is never high for more than the maximum phase cycle count. When that count is reached while idle, the pins return to the low half of the same code and busy stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vid_code_i | input | CODE_W (6) | Code to present on the next accepted request |
| upd_req_i | input | 1 | Update request; taken only while idle |
| vid_pins_o | output | CODE_W/2+1 (4) | Pin 3 is the phase select; pins 2:0 carry one half of the code |
| busy_o | output | 1 | High while a sequence is in progress |
| done_o | output | 1 | One-cycle pulse when the high phase has met its hold |

## Verification
The hardest case to reach from the ports is the return to the low half in park mode. It only happens after the block has sat idle on the high half for the full maximum phase length, with no request arriving in between. The bench shortens the hold and the maximum by setting a low clock-frequency parameter and a small cycle limit. It runs a park instance and a non-park instance side by side on identical stimulus, waits out the idle window, and then issues a request from the parked low half, where no phase edge occurs. A request raised in the middle of a sequence, with a different code on the input, checks that such requests are ignored and that the code is captured only at acceptance.

// File: rtl/vid_pkg.sv
// Package: shared state encoding and elaboration-time timing helpers for
// the voltage-ID pin driver. Assumes clock rates and times fit in 64 bits.
package vid_pkg;

    // Sequence state: low half, high half, or idle waiting for a request.
    typedef enum logic [1:0] {
        SEQ_LOW  = 2'd0,
        SEQ_HIGH = 2'd1,
        SEQ_IDLE = 2'd2
    } seq_state_t;

    // Convert a time in ns to clock cycles, rounding up.
    function automatic longint unsigned ns_to_cycles(
        input longint unsigned clk_hz,
        input longint unsigned ns
    );
        return (clk_hz * ns + 64'd999_999_999) / 64'd1_000_000_000;
    endfunction

endpackage

// File: rtl/vid_phase_timer.sv
// Module: phase-length counter. Counts the cycles spent in the current phase,
// is cleared by the sequencer on each phase change or accepted request, and
// saturates at MAX_CYC-1. Assumes 1 <= HOLD_CYC <= MAX_CYC.
module vid_phase_timer #(
    parameter int HOLD_CYC = 3500,
    parameter int MAX_CYC  = 172020
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    output logic hold_met_o,
    output logic max_met_o
);
    localparam int CNT_W = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(HOLD_CYC - 1);
    localparam logic [CNT_W-1:0] MAX_LAST  = CNT_W'(MAX_CYC - 1);

    logic [CNT_W-1:0] cnt_q;

    // Count cycles in the current phase, holding at the maximum.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            cnt_q <= '0;
        end else if (cnt_q != MAX_LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign hold_met_o = (cnt_q == HOLD_LAST);
    assign max_met_o  = (cnt_q == MAX_LAST);

endmodule

// File: rtl/vid_seq_fsm.sv
// Module: sequencer. Steps low half -> high half -> idle, captures the code
// when a request is accepted while idle, raises the completion pulse, and in
// park mode returns the phase to low once the high phase reaches its maximum.
// Assumes the timer flags refer to the phase chosen by this module.
module vid_seq_fsm
    import vid_pkg::*;
#(
    parameter int               CODE_W     = 6,
    parameter logic [CODE_W-1:0] RESET_CODE = '0,
    parameter bit               PARK_LSB   = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code_i,
    input  logic              req_i,
    input  logic              hold_met_i,
    input  logic              max_met_i,
    output logic              clr_o,
    output logic              phase_o,
    output logic [CODE_W-1:0] code_q_o,
    output logic              busy_o,
    output logic              done_o
);
    seq_state_t        st_q, st_n;
    logic              ph_q, ph_n;
    logic              load;
    logic              done_q, done_n;
    logic [CODE_W-1:0] code_q;

    // Next-state, phase, capture and completion decisions.
    always_comb begin
        st_n   = st_q;
        ph_n   = ph_q;
        load   = 1'b0;
        clr_o  = 1'b0;
        done_n = 1'b0;
        unique case (st_q)
            SEQ_LOW: begin
                if (hold_met_i) begin
                    st_n  = SEQ_HIGH;
                    ph_n  = 1'b1;
                    clr_o = 1'b1;
                end
            end
            SEQ_HIGH: begin
                if (hold_met_i) begin
                    st_n   = SEQ_IDLE;
                    done_n = 1'b1;
                    if (PARK_LSB && max_met_i) begin
                        ph_n  = 1'b0;
                        clr_o = 1'b1;
                    end
                end
            end
            SEQ_IDLE: begin
                if (req_i) begin
                    st_n  = SEQ_LOW;
                    ph_n  = 1'b0;
                    load  = 1'b1;
                    clr_o = 1'b1;
                end else if (PARK_LSB && ph_q && max_met_i) begin
                    ph_n  = 1'b0;
                    clr_o = 1'b1;
                end
            end
            default: begin
                st_n  = SEQ_LOW;
                ph_n  = 1'b0;
                clr_o = 1'b1;
            end
        endcase
    end

    // Register state, phase, captured code and the completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= SEQ_LOW;
            ph_q   <= 1'b0;
            code_q <= RESET_CODE;
            done_q <= 1'b0;
        end else begin
            st_q   <= st_n;
            ph_q   <= ph_n;
            done_q <= done_n;
            if (load) begin
                code_q <= code_i;
            end
        end
    end

    assign phase_o  = ph_q;
    assign code_q_o = code_q;
    assign busy_o   = (st_q != SEQ_IDLE);
    assign done_o   = done_q;

endmodule

// File: rtl/vid_pin_sel.sv
// Module: pin selector. Drives the phase pin and routes the matching half of
// the captured code onto the shared data pins. Inputs come straight from
// flops, so the data pins switch in the same cycle as the phase pin.
module vid_pin_sel #(
    parameter int DATA_W = 3
) (
    input  logic                phase_i,
    input  logic [2*DATA_W-1:0] code_i,
    output logic [DATA_W:0]     pins_o
);
    // One two-way selector per shared data pin.
    for (genvar g = 0; g < DATA_W; g++) begin : g_bit
        assign pins_o[g] = phase_i ? code_i[DATA_W + g] : code_i[g];
    end

    assign pins_o[DATA_W] = phase_i;

endmodule

// File: rtl/vid_pin_mux.sv
// Module: top of the voltage-ID pin driver. Converts the minimum hold time to
// cycles at elaboration, rejects a hold longer than the maximum phase length,
// and connects the timer, sequencer and pin selector.
// Assumes CODE_W is even and the reset input is synchronous and active low.
module vid_pin_mux #(
    parameter int unsigned       CLK_HZ        = 50_000_000,
    parameter int unsigned       MIN_HOLD_NS   = 70_000,
    parameter int                MAX_PHASE_CYC = 172_020,
    parameter int                CODE_W        = 6,
    parameter logic [CODE_W-1:0] RESET_CODE    = '0,
    parameter bit                PARK_LSB      = 1'b0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CODE_W-1:0]   vid_code_i,
    input  logic                upd_req_i,
    output logic [CODE_W/2:0]   vid_pins_o,
    output logic                busy_o,
    output logic                done_o
);
    localparam int DATA_W = CODE_W / 2;
    localparam longint unsigned HOLD_RAW =
        vid_pkg::ns_to_cycles(64'(CLK_HZ), 64'(MIN_HOLD_NS));
    localparam int HOLD_CYC = (HOLD_RAW == 0) ? 1 : int'(HOLD_RAW);

    // Elaboration check: the minimum hold must fit inside the maximum phase.
    if (HOLD_CYC > MAX_PHASE_CYC) begin : g_bad_timing
        $error("vid_pin_mux: minimum hold exceeds maximum phase length");
    end

    logic              clr;
    logic              hold_met;
    logic              max_met;
    logic              phase;
    logic [CODE_W-1:0] code_cap;

    vid_phase_timer #(
        .HOLD_CYC (HOLD_CYC),
        .MAX_CYC  (MAX_PHASE_CYC)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (clr),
        .hold_met_o (hold_met),
        .max_met_o  (max_met)
    );

    vid_seq_fsm #(
        .CODE_W     (CODE_W),
        .RESET_CODE (RESET_CODE),
        .PARK_LSB   (PARK_LSB)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .code_i     (vid_code_i),
        .req_i      (upd_req_i),
        .hold_met_i (hold_met),
        .max_met_i  (max_met),
        .clr_o      (clr),
        .phase_o    (phase),
        .code_q_o   (code_cap),
        .busy_o     (busy_o),
        .done_o     (done_o)
    );

    vid_pin_sel #(
        .DATA_W (DATA_W)
    ) u_pins (
        .phase_i (phase),
        .code_i  (code_cap),
        .pins_o  (vid_pins_o)
    );

endmodule

// File: rtl/vid_pin_mux_chk.sv
// Module: protocol checker bound to vid_pin_mux. Tracks how long the phase
// pin has held its value and checks hold, maximum, completion and capture
// rules against the top-level pins and the captured code.
module vid_pin_mux_chk #(
    parameter int CODE_W   = 6,
    parameter int HOLD_CYC = 3500,
    parameter int MAX_CYC  = 172020,
    parameter bit PARK_LSB = 1'b0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              upd_req_i,
    input logic              busy_i,
    input logic              done_i,
    input logic [CODE_W/2:0] vid_pins_i,
    input logic [CODE_W-1:0] code_q_i
);
    localparam int DATA_W = CODE_W / 2;
    localparam int RUN_W  = $clog2(MAX_CYC + 2);
    localparam logic [RUN_W-1:0] RUN_SAT = RUN_W'(MAX_CYC + 1);

    logic             last_ph;
    logic [RUN_W-1:0] run;

    // Count consecutive cycles for which the phase pin kept its value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_ph <= 1'b0;
            run     <= RUN_W'(1);
        end else begin
            last_ph <= vid_pins_i[DATA_W];
            if (vid_pins_i[DATA_W] != last_ph) begin
                run <= RUN_W'(1);
            end else if (run != RUN_SAT) begin
                run <= run + 1'b1;
            end
        end
    end

    a_r4_min_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (vid_pins_i[DATA_W] != last_ph) |-> (run >= RUN_W'(HOLD_CYC)));

    a_r10_max_high: assert property (@(posedge clk) disable iff (!rst_n)
        (PARK_LSB && vid_pins_i[DATA_W] && last_ph) |-> (run < RUN_W'(MAX_CYC)));

    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |=> !done_i);

    a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |-> !busy_i);

    a_r6_done_on_finish: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_i) |-> done_i);

    a_r7_capture_idle_only: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(code_q_i) |-> $past(upd_req_i && !busy_i));

endmodule

bind vid_pin_mux vid_pin_mux_chk #(
    .CODE_W   (CODE_W),
    .HOLD_CYC (HOLD_CYC),
    .MAX_CYC  (MAX_PHASE_CYC),
    .PARK_LSB (PARK_LSB)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .upd_req_i  (upd_req_i),
    .busy_i     (busy_o),
    .done_i     (done_o),
    .vid_pins_i (vid_pins_o),
    .code_q_i   (code_cap)
);

// File: tb/vid_pin_mux_tb.sv
// Bench: two instances (hold-high and park-low) share one stimulus and are
// compared every clock with a behavioural model plus directed checks.
module vid_pin_mux_tb;
    localparam int unsigned CLK_HZ  = 1_000_000;
    localparam int unsigned HOLD_NS = 70_000;
    localparam int H   = 70;   // 70000 ns at 1 MHz, rounded up
    localparam int M   = 150;
    localparam logic [5:0] RST_CODE = 6'b101_011;
    localparam logic [5:0] C1 = 6'b110_001;
    localparam logic [5:0] C2 = 6'b001_110;
    localparam logic [5:0] C3 = 6'b011_100;
    localparam logic [5:0] C4 = 6'b010_101;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] vin = '0;
    logic       req = 1'b0;
    logic [3:0] pins [2];
    logic       busy [2];
    logic       done [2];

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    vid_pin_mux #(.CLK_HZ(CLK_HZ), .MIN_HOLD_NS(HOLD_NS), .MAX_PHASE_CYC(M),
                  .CODE_W(6), .RESET_CODE(RST_CODE), .PARK_LSB(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .vid_code_i(vin), .upd_req_i(req),
        .vid_pins_o(pins[0]), .busy_o(busy[0]), .done_o(done[0]));

    vid_pin_mux #(.CLK_HZ(CLK_HZ), .MIN_HOLD_NS(HOLD_NS), .MAX_PHASE_CYC(M),
                  .CODE_W(6), .RESET_CODE(RST_CODE), .PARK_LSB(1'b1)) u_dut_park (
        .clk(clk), .rst_n(rst_n), .vid_code_i(vin), .upd_req_i(req),
        .vid_pins_o(pins[1]), .busy_o(busy[1]), .done_o(done[1]));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural model: state 0 low half, 1 high half, 2 idle.
    int         m_st  [2];
    int         m_len [2];
    bit         m_hi  [2];
    bit         m_done[2];
    logic [5:0] m_code[2];

    function automatic logic [3:0] exp_pins(input int i);
        return {m_hi[i], m_hi[i] ? m_code[i][5:3] : m_code[i][2:0]};
    endfunction

    always @(posedge clk) begin
        for (int i = 0; i < 2; i++) begin
            if (!rst_n) begin
                m_st[i] = 0; m_len[i] = 0; m_hi[i] = 0; m_done[i] = 0; m_code[i] = RST_CODE;
            end else begin
                m_done[i] = 0;
                if (m_st[i] == 0) begin
                    if (m_len[i] == H - 1) begin m_st[i] = 1; m_hi[i] = 1; m_len[i] = 0; end
                    else m_len[i]++;
                end else if (m_st[i] == 1) begin
                    if (m_len[i] == H - 1) begin
                        m_st[i] = 2; m_done[i] = 1;
                        if (i == 1 && m_len[i] == M - 1) begin m_hi[i] = 0; m_len[i] = 0; end
                        else m_len[i]++;
                    end else m_len[i]++;
                end else begin
                    if (req) begin m_st[i] = 0; m_hi[i] = 0; m_code[i] = vin; m_len[i] = 0; end
                    else if (i == 1 && m_hi[i] && m_len[i] == M - 1) begin m_hi[i] = 0; m_len[i] = 0; end
                    else if (m_len[i] < M - 1) m_len[i]++;
                end
            end
        end
    end

    // Per-clock comparison against the model (R3 pins, R7 busy, R6 done).
    always @(negedge clk) begin
        if (!finished) begin
            for (int i = 0; i < 2; i++) begin
                chk("R3 pins vs model", 32'(pins[i]), 32'(exp_pins(i)));
                chk("R7 busy vs model", 32'(busy[i]), 32'(m_st[i] != 2));
                chk("R6 done vs model", 32'(done[i]), 32'(m_done[i]));
            end
        end
    end

    task automatic wait_for_high();
        for (int k = 0; k < 4 * M; k++) begin
            @(negedge clk);
            if (pins[0][3]) break;
        end
    endtask

    task automatic wait_for_done();
        for (int k = 0; k < 4 * M; k++) begin
            @(negedge clk);
            if (done[0]) break;
        end
    endtask

    initial begin
        repeat (200_000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        for (int i = 0; i < 2; i++) begin
            chk("R1 reset pins", 32'(pins[i]), 32'({1'b0, RST_CODE[2:0]}));
            chk("R1 reset busy", 32'(busy[i]), 32'd1);
            chk("R1 reset done", 32'(done[i]), 32'd0);
        end
        rst_n = 1'b1;
        repeat (H - 1) @(negedge clk);
        chk("R4 low phase still held", 32'(pins[0][3]), 32'd0);
        @(negedge clk);
        chk("R2 phase rises after reset", 32'(pins[0][3]), 32'd1);
        chk("R5 data with phase edge", 32'(pins[0][2:0]), 32'(RST_CODE[5:3]));
        repeat (H - 1) @(negedge clk);
        chk("R4 high phase still busy", 32'(busy[0]), 32'd1);
        @(negedge clk);
        chk("R6 done pulse", 32'(done[0]), 32'd1);
        chk("R6 busy low with done", 32'(busy[0]), 32'd0);
        @(negedge clk);
        chk("R6 done single cycle", 32'(done[0]), 32'd0);

        vin = C1; req = 1'b1;
        @(negedge clk);
        req = 1'b0; vin = C2;
        for (int i = 0; i < 2; i++) begin
            chk("R8 accepted low half", 32'(pins[i]), 32'({1'b0, C1[2:0]}));
            chk("R7 accepted when idle", 32'(busy[i]), 32'd1);
        end
        repeat (10) @(negedge clk);
        vin = C3; req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        wait_for_high();
        chk("R8 captured high half", 32'(pins[0][2:0]), 32'(C1[5:3]));
        wait_for_done();
        repeat (5) @(negedge clk);
        chk("R7 busy request ignored", 32'(busy[0]), 32'd0);
        chk("R7 busy request ignored park", 32'(busy[1]), 32'd0);

        repeat (M + 10) @(negedge clk);
        chk("R9 holds high half", 32'(pins[0]), 32'({1'b1, C1[5:3]}));
        chk("R10 parked low half", 32'(pins[1]), 32'({1'b0, C1[2:0]}));
        chk("R10 parked not busy", 32'(busy[1]), 32'd0);

        vin = C4; req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        chk("R8 accept from parked low", 32'(pins[1]), 32'({1'b0, C4[2:0]}));
        wait_for_done();
        repeat (M + 5) @(negedge clk);
        chk("R10 second park", 32'(pins[1]), 32'({1'b0, C4[2:0]}));
        chk("R9 second hold", 32'(pins[0]), 32'({1'b1, C4[5:3]}));

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule